// File: doc/BRIEF.md
# Retirement Queue with Precise Fault Handling

This block keeps the program order of in-flight instructions for an out-of-order core. Each instruction takes a slot at dispatch. The block records the instruction's architectural destination, its newly assigned physical tag, the physical tag it replaces, and its program counter, and it returns the slot index to the dispatcher. Execution units then report completion in any order, giving the slot index and a flag that says whether the instruction faulted.

Results become architectural only at the oldest slot, the head. If the head has completed cleanly, it is committed and its tags are sent out, so the renamer can free the old tag. If the head completed with a fault, it is not committed. Instead the block emits a one-cycle exception carrying the stored program counter and raises a squash. In the following cycle it discards that slot and every younger one. The architectural state therefore reflects exactly the instructions older than the faulting one. A fault on any other slot is only recorded, and the machine keeps running.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `commit_valid_o`, `exc_valid_o` and `squash_o` are 0.
- R2: Each accepted allocation takes the slot shown on `alloc_idx_o`. Consecutive allocations get consecutive indices, wrapping from DEPTH-1 back to 0.
- R3: With DEPTH slots occupied, `alloc_ready_o` is 0 and a request is ignored. The returned index does not move and no stored entry changes.
- R4: Commits happen strictly in allocation order, at most one per cycle. A commit appears only for a head slot that has completed without a fault, and `commit_valid_o` rises on the second rising edge after the completion is presented for the head.
- R5: A younger slot that completes before an older one is not committed until every older slot has been committed.
- R6: When the head slot completes with a fault, `exc_valid_o` is high for exactly one cycle and `exc_pc_o` carries that slot's program counter. Neither that slot nor any younger slot ever commits.
- R7: `squash_o` is high in the same cycle as `exc_valid_o`. In the next cycle the queue is empty again, with `alloc_idx_o` = 0 and `alloc_ready_o` = 1. Allocation is refused during the squash cycle.
- R8: A completion whose index names a slot that is not allocated, including a slot freed by a squash, is ignored. The slot still waits for its own completion after it is later allocated.
- R9: A fault flag on a slot that is not at the head raises no exception and no squash until that slot reaches the head.
- R10: The commit output presents the destination, new tag and old tag stored at allocation for the committed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Dispatch requests a slot |
| alloc_dst_i | input | ARCH_W | Architectural destination register |
| alloc_new_tag_i | input | PTAG_W | Physical tag assigned to the destination |
| alloc_old_tag_i | input | PTAG_W | Physical tag previously mapped to the destination |
| alloc_pc_i | input | PC_W | Program counter of the instruction |
| alloc_ready_o | output | 1 | A slot is free and no squash is in progress |
| alloc_idx_o | output | IDX_W | Slot index the next accepted allocation takes |
| cmpl_valid_i | input | 1 | Completion report valid |
| cmpl_idx_i | input | IDX_W | Slot index being completed |
| cmpl_fault_i | input | 1 | Completed instruction raised a fault |
| commit_valid_o | output | 1 | One slot committed this cycle |
| commit_dst_o | output | ARCH_W | Committed destination register |
| commit_new_tag_o | output | PTAG_W | Committed new physical tag |
| commit_old_tag_o | output | PTAG_W | Physical tag now free for reuse |
| exc_valid_o | output | 1 | Precise exception, one-cycle pulse |
| exc_pc_o | output | PC_W | Program counter of the faulting instruction |
| squash_o | output | 1 | All in-flight slots are being discarded |

## Verification
Faults in the internal state appear at the ports in specific ways. A head pointer that drifts produces commits whose tags do not match the allocation order. An occupancy count that drifts shows up either as `alloc_ready_o` dropping before sixteen slots are held, or as the returned index failing to stop when the queue is full. A slot whose completion is lost or wrongly accepted either stalls every later commit or commits too early. The scoreboard catches both within a few cycles, because each commit must match the next queued allocation and every unexpected commit is flagged. A squash that clears too little or too late leaves a nonzero index or blocked allocation in the cycle after the exception, and it lets younger faulted slots commit.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic valid;
    logic done;
    logic fault;
  } slot_state_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic             retire_fire_i,
  input  logic             exc_fire_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic             squash_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             squash_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      tail_q   <= '0;
      count_q  <= '0;
      squash_q <= 1'b0;
    end else if (squash_q) begin
      head_q   <= '0;
      tail_q   <= '0;
      count_q  <= '0;
      squash_q <= 1'b0;
    end else begin
      squash_q <= exc_fire_i;
      if (alloc_fire_i)  tail_q <= bump(tail_q);
      if (retire_fire_i) head_q <= bump(head_q);
      count_q <= count_q + CNT_W'(alloc_fire_i) - CNT_W'(retire_fire_i);
    end
  end

  assign head_o   = head_q;
  assign tail_o   = tail_q;
  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign squash_o = squash_q;

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R3
  no_overfill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !alloc_fire_i);
  // R7
  squash_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_q |=> (count_q == '0 && head_q == '0 && tail_q == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned IDX_W  = $clog2(DEPTH),
  parameter int unsigned ARCH_W = 5,
  parameter int unsigned PTAG_W = 6,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_fire_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [ARCH_W-1:0] alloc_dst_i,
  input  logic [PTAG_W-1:0] alloc_new_tag_i,
  input  logic [PTAG_W-1:0] alloc_old_tag_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic              cmpl_fault_i,
  input  logic              retire_fire_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic              squash_i,
  output slot_state_t       head_state_o,
  output logic [ARCH_W-1:0] head_dst_o,
  output logic [PTAG_W-1:0] head_new_tag_o,
  output logic [PTAG_W-1:0] head_old_tag_o,
  output logic [PC_W-1:0]   head_pc_o
);
  logic [DEPTH-1:0]  valid_q, done_q, fault_q;
  logic [ARCH_W-1:0] dst_q  [DEPTH];
  logic [PTAG_W-1:0] ntag_q [DEPTH];
  logic [PTAG_W-1:0] otag_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic v_q, d_q, f_q;
    logic hit_alloc, hit_cmpl, hit_retire;

    assign hit_alloc  = alloc_fire_i && (tail_i == IDX_W'(i));
    assign hit_cmpl   = cmpl_valid_i && (cmpl_idx_i == IDX_W'(i)) && v_q;
    assign hit_retire = retire_fire_i && (head_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        f_q <= 1'b0;
      end else if (squash_i) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        f_q <= 1'b0;
      end else if (hit_alloc) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        f_q <= 1'b0;
      end else begin
        if (hit_retire) v_q <= 1'b0;
        if (hit_cmpl) begin
          d_q <= 1'b1;
          f_q <= cmpl_fault_i;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (hit_alloc) begin
        dst_q[i]  <= alloc_dst_i;
        ntag_q[i] <= alloc_new_tag_i;
        otag_q[i] <= alloc_old_tag_i;
        pc_q[i]   <= alloc_pc_i;
      end
    end

    assign valid_q[i] = v_q;
    assign done_q[i]  = d_q;
    assign fault_q[i] = f_q;
  end

  assign head_state_o.valid = valid_q[head_i];
  assign head_state_o.done  = done_q[head_i];
  assign head_state_o.fault = fault_q[head_i];
  assign head_dst_o         = dst_q[head_i];
  assign head_new_tag_o     = ntag_q[head_i];
  assign head_old_tag_o     = otag_q[head_i];
  assign head_pc_o          = pc_q[head_i];

  // R8
  idle_cmpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && !valid_q[cmpl_idx_i]) |=> !done_q[$past(cmpl_idx_i)]);
  // R4
  head_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_fire_i |-> (valid_q[head_i] && done_q[head_i] && !fault_q[head_i]));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int unsigned ARCH_W = 5,
  parameter int unsigned PTAG_W = 6,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_state_t       head_state_i,
  input  logic [ARCH_W-1:0] head_dst_i,
  input  logic [PTAG_W-1:0] head_new_tag_i,
  input  logic [PTAG_W-1:0] head_old_tag_i,
  input  logic [PC_W-1:0]   head_pc_i,
  input  logic              squash_i,
  output logic              retire_fire_o,
  output logic              exc_fire_o,
  output logic              commit_valid_o,
  output logic [ARCH_W-1:0] commit_dst_o,
  output logic [PTAG_W-1:0] commit_new_tag_o,
  output logic [PTAG_W-1:0] commit_old_tag_o,
  output logic              exc_valid_o,
  output logic [PC_W-1:0]   exc_pc_o
);
  logic head_ok;
  logic commit_q, exc_q;

  assign head_ok       = head_state_i.valid && head_state_i.done && !squash_i;
  assign retire_fire_o = head_ok && !head_state_i.fault;
  assign exc_fire_o    = head_ok && head_state_i.fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q         <= 1'b0;
      exc_q            <= 1'b0;
      commit_dst_o     <= '0;
      commit_new_tag_o <= '0;
      commit_old_tag_o <= '0;
      exc_pc_o         <= '0;
    end else begin
      commit_q <= retire_fire_o;
      exc_q    <= exc_fire_o;
      if (retire_fire_o) begin
        commit_dst_o     <= head_dst_i;
        commit_new_tag_o <= head_new_tag_i;
        commit_old_tag_o <= head_old_tag_i;
      end
      if (exc_fire_o) exc_pc_o <= head_pc_i;
    end
  end

  assign commit_valid_o = commit_q;
  assign exc_valid_o    = exc_q;

  // R6
  exc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |=> !exc_q);
  // R6
  exc_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |-> !commit_q);
  // R7
  exc_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |-> squash_i);
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ARCH_W = 5,
  parameter int unsigned PTAG_W = 6,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_req_i,
  input  logic [ARCH_W-1:0] alloc_dst_i,
  input  logic [PTAG_W-1:0] alloc_new_tag_i,
  input  logic [PTAG_W-1:0] alloc_old_tag_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic              cmpl_fault_i,
  output logic              commit_valid_o,
  output logic [ARCH_W-1:0] commit_dst_o,
  output logic [PTAG_W-1:0] commit_new_tag_o,
  output logic [PTAG_W-1:0] commit_old_tag_o,
  output logic              exc_valid_o,
  output logic [PC_W-1:0]   exc_pc_o,
  output logic              squash_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]  head, tail;
  logic              full, squash, alloc_fire, retire_fire, exc_fire;
  slot_state_t       head_state;
  logic [ARCH_W-1:0] head_dst;
  logic [PTAG_W-1:0] head_ntag, head_otag;
  logic [PC_W-1:0]   head_pc;

  assign alloc_ready_o = !full && !squash;
  assign alloc_fire    = alloc_req_i && alloc_ready_o;
  assign alloc_idx_o   = tail;
  assign squash_o      = squash;

  rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_fire_i  (alloc_fire),
    .retire_fire_i (retire_fire),
    .exc_fire_i    (exc_fire),
    .head_o        (head),
    .tail_o        (tail),
    .full_o        (full),
    .squash_o      (squash)
  );

  rob_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .ARCH_W(ARCH_W), .PTAG_W(PTAG_W), .PC_W(PC_W)
  ) u_store (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .alloc_fire_i    (alloc_fire),
    .tail_i          (tail),
    .alloc_dst_i     (alloc_dst_i),
    .alloc_new_tag_i (alloc_new_tag_i),
    .alloc_old_tag_i (alloc_old_tag_i),
    .alloc_pc_i      (alloc_pc_i),
    .cmpl_valid_i    (cmpl_valid_i),
    .cmpl_idx_i      (cmpl_idx_i),
    .cmpl_fault_i    (cmpl_fault_i),
    .retire_fire_i   (retire_fire),
    .head_i          (head),
    .squash_i        (squash),
    .head_state_o    (head_state),
    .head_dst_o      (head_dst),
    .head_new_tag_o  (head_ntag),
    .head_old_tag_o  (head_otag),
    .head_pc_o       (head_pc)
  );

  rob_retire #(.ARCH_W(ARCH_W), .PTAG_W(PTAG_W), .PC_W(PC_W)) u_retire (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .head_state_i     (head_state),
    .head_dst_i       (head_dst),
    .head_new_tag_i   (head_ntag),
    .head_old_tag_i   (head_otag),
    .head_pc_i        (head_pc),
    .squash_i         (squash),
    .retire_fire_o    (retire_fire),
    .exc_fire_o       (exc_fire),
    .commit_valid_o   (commit_valid_o),
    .commit_dst_o     (commit_dst_o),
    .commit_new_tag_o (commit_new_tag_o),
    .commit_old_tag_o (commit_old_tag_o),
    .exc_valid_o      (exc_valid_o),
    .exc_pc_o         (exc_pc_o)
  );

  // R7
  no_alloc_in_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash |-> !alloc_fire);
endmodule

// File: tb/retire_queue_tb.sv
`timescale 1ns/1ps
module retire_queue_tb;
  localparam int ARCH_W = 5;
  localparam int PTAG_W = 6;
  localparam int PC_W   = 32;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = 4;
  localparam int CW     = ARCH_W + 2 * PTAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic              alloc_req_i = 1'b0;
  logic [ARCH_W-1:0] alloc_dst_i = '0;
  logic [PTAG_W-1:0] alloc_new_tag_i = '0, alloc_old_tag_i = '0;
  logic [PC_W-1:0]   alloc_pc_i = '0;
  logic              alloc_ready_o;
  logic [IDX_W-1:0]  alloc_idx_o;
  logic              cmpl_valid_i = 1'b0, cmpl_fault_i = 1'b0;
  logic [IDX_W-1:0]  cmpl_idx_i = '0;
  logic              commit_valid_o;
  logic [ARCH_W-1:0] commit_dst_o;
  logic [PTAG_W-1:0] commit_new_tag_o, commit_old_tag_o;
  logic              exc_valid_o;
  logic [PC_W-1:0]   exc_pc_o;
  logic              squash_o;

  always #4 clk = ~clk;

  retire_queue #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PTAG_W(PTAG_W), .PC_W(PC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_req_i(alloc_req_i), .alloc_dst_i(alloc_dst_i),
    .alloc_new_tag_i(alloc_new_tag_i), .alloc_old_tag_i(alloc_old_tag_i),
    .alloc_pc_i(alloc_pc_i), .alloc_ready_o(alloc_ready_o), .alloc_idx_o(alloc_idx_o),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_idx_i(cmpl_idx_i), .cmpl_fault_i(cmpl_fault_i),
    .commit_valid_o(commit_valid_o), .commit_dst_o(commit_dst_o),
    .commit_new_tag_o(commit_new_tag_o), .commit_old_tag_o(commit_old_tag_o),
    .exc_valid_o(exc_valid_o), .exc_pc_o(exc_pc_o), .squash_o(squash_o)
  );

  int n_chk = 0, n_fail = 0, n_commit = 0, n_exc = 0;
  bit finished = 1'b0;
  logic [CW-1:0] exp_q[$];
  logic [CW-1:0] mon_got, mon_exp;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every commit must match the oldest expected entry
  always @(negedge clk) begin
    if (rst_n && exc_valid_o) n_exc++;
    if (rst_n && commit_valid_o) begin
      n_commit++;
      mon_got = {commit_dst_o, commit_new_tag_o, commit_old_tag_o};
      if (exp_q.size() == 0) chk(1'b0, "R4/R6 unexpected commit", mon_got, 0);
      else begin
        mon_exp = exp_q.pop_front();
        chk(mon_got == mon_exp, "R10/R4 commit fields in order", mon_got, mon_exp);
      end
    end
  end

  task automatic do_alloc(input int d, input int nt, input int ot, input int pc,
                          input bit keep, output logic [IDX_W-1:0] idx);
    alloc_req_i     = 1'b1;
    alloc_dst_i     = ARCH_W'(d);
    alloc_new_tag_i = PTAG_W'(nt);
    alloc_old_tag_i = PTAG_W'(ot);
    alloc_pc_i      = PC_W'(pc);
    idx = alloc_idx_o;
    if (keep) exp_q.push_back({ARCH_W'(d), PTAG_W'(nt), PTAG_W'(ot)});
    @(negedge clk);
    alloc_req_i = 1'b0;
  endtask

  task automatic do_cmpl(input int idx, input bit f);
    cmpl_valid_i = 1'b1;
    cmpl_idx_i   = IDX_W'(idx);
    cmpl_fault_i = f;
    @(negedge clk);
    cmpl_valid_i = 1'b0;
    cmpl_fault_i = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] ix[3];
    bit wrap_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready_o == 1'b1, "R1 ready after reset", alloc_ready_o, 1);
    chk(alloc_idx_o == 0, "R1 index after reset", alloc_idx_o, 0);
    chk(!commit_valid_o && !exc_valid_o && !squash_o, "R1 outputs idle",
        {commit_valid_o, exc_valid_o, squash_o}, 0);

    // R2 in-order slots, R5 out-of-order completion held back
    do_alloc(1, 10, 20, 'h100, 1'b1, ix[0]);
    do_alloc(2, 11, 21, 'h104, 1'b1, ix[1]);
    do_alloc(3, 12, 22, 'h108, 1'b1, ix[2]);
    chk(ix[0] == 0 && ix[1] == 1 && ix[2] == 2, "R2 sequential indices",
        {ix[0], ix[1], ix[2]}, 'h012);
    do_cmpl(2, 1'b0);
    do_cmpl(1, 1'b0);
    repeat (3) @(negedge clk);
    chk(n_commit == 0, "R5 younger done, no commit", n_commit, 0);
    // R4 head completion releases all three
    do_cmpl(0, 1'b0);
    chk(n_commit == 0 && !commit_valid_o, "R4 commit not before second edge", n_commit, 0);
    @(negedge clk);
    chk(commit_valid_o == 1'b1, "R4 commit on second edge", commit_valid_o, 1);
    drain("R4 drain first group");
    chk(n_commit == 3, "R4 commit count", n_commit, 3);

    // R8 completions for unallocated slots ignored
    do_cmpl(5, 1'b0);
    do_cmpl(4, 1'b1);
    do_alloc(4, 13, 23, 'h10c, 1'b1, ix[0]);
    do_alloc(5, 14, 24, 'h110, 1'b1, ix[1]);
    do_alloc(6, 15, 25, 'h114, 1'b1, ix[2]);
    repeat (4) @(negedge clk);
    chk(n_commit == 3, "R8 stale completion ignored", n_commit, 3);
    chk(n_exc == 0, "R8 stale fault ignored", n_exc, 0);
    do_cmpl(ix[0], 1'b0);
    do_cmpl(ix[1], 1'b0);
    do_cmpl(ix[2], 1'b0);
    drain("R8 drain second group");
    chk(n_commit == 6, "R8 commit count", n_commit, 6);

    // R3 fill to depth, R2 wrap
    wrap_ok = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      do_alloc(k + 8, k + 30, k + 1, 'h200 + k * 4, 1'b1, idx);
      if (idx != IDX_W'((6 + k) % DEPTH)) wrap_ok = 1'b0;
    end
    chk(wrap_ok, "R2 indices wrap", wrap_ok, 1);
    chk(alloc_ready_o == 1'b0, "R3 not ready when full", alloc_ready_o, 0);
    do_alloc(31, 63, 63, 'hdead, 1'b0, idx);
    chk(alloc_idx_o == 6, "R3 full request ignored", alloc_idx_o, 6);
    for (int k = DEPTH - 1; k >= 0; k--) do_cmpl((6 + k) % DEPTH, 1'b0);
    drain("R3 drain full queue");
    chk(n_commit == 22, "R3 commit count", n_commit, 22);

    // R6/R7/R9 precise fault at head
    do_alloc(7, 40, 41, 'h1000, 1'b1, ix[0]);
    do_alloc(8, 42, 43, 'h1234, 1'b0, ix[1]);
    do_alloc(9, 44, 45, 'h1238, 1'b0, ix[2]);
    do_cmpl(ix[2], 1'b1);
    do_cmpl(ix[1], 1'b1);
    repeat (3) @(negedge clk);
    chk(n_exc == 0 && !squash_o, "R9 non-head fault deferred", n_exc, 0);
    do_cmpl(ix[0], 1'b0);
    for (int i = 0; i < 10 && !exc_valid_o; i++) @(negedge clk);
    chk(exc_valid_o == 1'b1, "R6 exception raised", exc_valid_o, 1);
    chk(exc_pc_o == 'h1234, "R6 exception pc", exc_pc_o, 'h1234);
    chk(squash_o == 1'b1, "R7 squash with exception", squash_o, 1);
    chk(alloc_ready_o == 1'b0, "R7 no alloc during squash", alloc_ready_o, 0);
    chk(n_commit == 23, "R6 older entry committed", n_commit, 23);
    @(negedge clk);
    chk(exc_valid_o == 1'b0, "R6 exception one cycle", exc_valid_o, 0);
    chk(squash_o == 1'b0, "R7 squash one cycle", squash_o, 0);
    chk(alloc_idx_o == 0 && alloc_ready_o, "R7 empty after squash",
        {alloc_ready_o, alloc_idx_o}, 'h10);
    repeat (4) @(negedge clk);
    chk(n_commit == 23 && n_exc == 1, "R6 squashed entries never commit", n_commit, 23);

    // R8 completion to a squashed slot ignored, then recovery
    do_cmpl(0, 1'b1);
    do_alloc(10, 50, 51, 'h2000, 1'b1, idx);
    chk(idx == 0, "R7 restart at slot 0", idx, 0);
    repeat (3) @(negedge clk);
    chk(n_commit == 23 && n_exc == 1, "R8 squashed slot completion ignored", n_commit, 23);
    do_cmpl(0, 1'b0);
    drain("R4 recovery commit");
    chk(n_commit == 24 && n_exc == 1, "R4 final counts", n_commit, 24);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule